// File: doc/BRIEF.md
# Time-of-Day Clock-Domain Synchronizer

This block hands a running time-of-day value from a master clock domain to a slave clock domain. The two clocks may differ in frequency, ppm or phase. The slave keeps its own time-of-day counter, which advances by one slave clock period on every slave cycle. At regular intervals, the counter is reloaded from a coherent snapshot of the master value. A third clock, the sampling clock, is supplied from outside and runs at a rational offset from the master, roughly 63 against 64. It drives the crossing, so its edges drift slowly across the phase of the other clocks.

The snapshot crosses the domains in two steps. First, a toggle request is sent from the sampling domain into the master domain, and a toggle acknowledge comes back. Then a ready toggle goes from the sampling domain to the slave. Every toggle passes through a two-flop synchronizer, and the multi-bit word is read only while it is held steady. When the slave loads a snapshot, it adds a fixed number of its own periods to cover the known latency of the crossing. It then marks the output valid and raises a one-cycle load strobe.

Compile-time parameters choose the format and the clock pairing. The format is either 96 bits (seconds, nanoseconds, fractional nanoseconds) or 64 bits (nanoseconds, fractional nanoseconds). The clock pairing is one of seven fixed choices, and one of them is an equal-frequency pairing whose period is set by parameters.

Top module: `tod_sync`

## Requirements
- R1: With TOD_FMT=1 (default), a ToD word is 96 bits: seconds in [95:64], nanoseconds in [63:16], fractional nanoseconds (units of 2^-16 ns) in [15:0].
- R2: With TOD_FMT=0, a ToD word is 64 bits: nanoseconds in [63:16] and fractional nanoseconds in [15:0]. There is no 10^9 rollover, and the word wraps modulo 2^64.
- R3: While the output is valid, on every slave cycle without a load the output advances by the slave period, given in 2^-16 ns units. The period depends on SYNC_MODE:
  - modes 1 and 6: 0x80000 (8 ns)
  - modes 0 and 4: 0x66666 (6.4 ns)
  - modes 3 and 5: 0x33333 (3.2 ns)
- R4: With SYNC_MODE=2, the slave period is PERIOD_NS*65536 + PERIOD_FNS.
- R5: On a load, the output equals the captured master word plus COMP_CYCLES slave periods, using the same rollover rules as stepping.
- R6: In the 96-bit format, when a sum brings the nanosecond field to 1,000,000,000 or more, 10^9 ns is subtracted from the nanosecond field and the seconds field rises by one (modulo 2^32). This applies both to stepping and to the load compensation.
- R7: After reset, the block stays in an invalid state until the first load:
  - slv_valid is 0, slv_tod is 0 and slv_load is 0;
  - slv_valid goes to 1 together with the first load strobe;
  - slv_valid stays 1 until the next reset.
- R8: slv_load is a one-cycle pulse that recurs. Once mst_tod is held steady, the second strobe after the change, and every strobe after it, carries that value compensated per R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master domain clock |
| mst_tod | input | TOD_W | Master time of day (96 or 64 bits) |
| smp_clk | input | 1 | Sampling clock, offset in rate from the master |
| slv_clk | input | 1 | Slave domain clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of all three clocks |
| slv_tod | output | TOD_W | Slave time of day |
| slv_load | output | 1 | One-cycle strobe on each reload |
| slv_valid | output | 1 | Output holds a loaded, running value |

## Verification
Stepping is checked one slave cycle after the output it derives from, so every falling-edge sample is compared against the previous sample advanced by one period. A load value shows up in the same slave cycle as its strobe. Because an earlier capture may still be in flight when the master value changes, the bench compares only the second strobe after each change, and every strobe after that, against the new master value. Reset values are checked after several edges of every clock with reset held.

// File: rtl/tod_sync_pkg.sv
`timescale 1ns/1ps
package tod_sync_pkg;

    localparam int SEC_W = 32;
    localparam int NS_W  = 48;
    localparam int FNS_W = 16;
    localparam logic [NS_W-1:0] NS_PER_SEC = 48'd1_000_000_000;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [FNS_W-1:0] fns;
    } tod_t;

    // Slave period in 2^-16 ns units for a clock pairing.
    function automatic logic [63:0] mode_inc(int mode, int pns, int pfns);
        logic [63:0] r;
        case (mode)
            0, 4:    r = 64'h66666;
            1, 6:    r = 64'h80000;
            2:       r = (64'(pns) << FNS_W) + 64'(pfns);
            3, 5:    r = 64'h33333;
            default: r = 64'h80000;
        endcase
        return r;
    endfunction

    // Advance a time-of-day by d fractional-ns units, with optional 1e9 rollover.
    function automatic tod_t tod_adv(tod_t t, logic [63:0] d, logic wrap);
        tod_t        r;
        logic [63:0] s;
        s     = {t.ns, t.fns} + d;
        r.sec = t.sec;
        if (wrap && (s[63:16] >= NS_PER_SEC)) begin
            s     = s - {NS_PER_SEC, 16'h0000};
            r.sec = t.sec + 32'd1;
        end
        r.ns  = s[63:16];
        r.fns = s[15:0];
        return r;
    endfunction

endpackage

// File: rtl/tod_sync_bitsync.sv
`timescale 1ns/1ps
module tod_sync_bitsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/tod_sync_capture.sv
`timescale 1ns/1ps
module tod_sync_capture #(
    parameter int W      = 96,
    parameter int STAGES = 2
) (
    input  logic         mst_clk,
    input  logic         rst,
    input  logic [W-1:0] mst_tod,
    input  logic         req_tgl,
    output logic [W-1:0] hold,
    output logic         ack_tgl
);
    logic req_s;
    logic req_d;

    tod_sync_bitsync #(.STAGES(STAGES)) u_req_sync (
        .clk (mst_clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    // A request edge freezes the master word; it stays put until the next request.
    always_ff @(posedge mst_clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            ack_tgl <= 1'b0;
            hold    <= '0;
        end else begin
            req_d <= req_s;
            if (req_s != req_d) begin
                hold    <= mst_tod;
                ack_tgl <= ~ack_tgl;
            end
        end
    end
endmodule

// File: rtl/tod_sync_sampler.sv
`timescale 1ns/1ps
module tod_sync_sampler #(
    parameter int W      = 96,
    parameter int STAGES = 2,
    parameter int GAP    = 16
) (
    input  logic         smp_clk,
    input  logic         rst,
    input  logic [W-1:0] hold,
    input  logic         ack_tgl,
    output logic         req_tgl,
    output logic [W-1:0] word,
    output logic         rdy_tgl
);
    localparam int CW = $clog2(GAP + 1);

    logic          ack_s;
    logic          ack_d;
    logic          busy;
    logic [CW-1:0] cnt;

    tod_sync_bitsync #(.STAGES(STAGES)) u_ack_sync (
        .clk (smp_clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    always_ff @(posedge smp_clk) begin
        if (rst) begin
            ack_d   <= 1'b0;
            busy    <= 1'b0;
            cnt     <= '0;
            req_tgl <= 1'b0;
            rdy_tgl <= 1'b0;
            word    <= '0;
        end else if (busy) begin
            if (ack_s != ack_d) begin
                ack_d   <= ack_s;
                word    <= hold;
                rdy_tgl <= ~rdy_tgl;
                busy    <= 1'b0;
            end
        end else if (cnt == CW'(GAP - 1)) begin
            cnt     <= '0;
            req_tgl <= ~req_tgl;
            busy    <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tod_sync_slave.sv
`timescale 1ns/1ps
module tod_sync_slave
    import tod_sync_pkg::*;
#(
    parameter int          W       = 96,
    parameter int          STAGES  = 2,
    parameter int          TOD_FMT = 1,
    parameter logic [63:0] INC     = 64'h80000,
    parameter int          COMP    = 3
) (
    input  logic         slv_clk,
    input  logic         rst,
    input  logic [W-1:0] word,
    input  logic         rdy_tgl,
    output logic [W-1:0] tod,
    output logic         load,
    output logic         valid
);
    localparam logic [63:0] COMP_FNS = INC * 64'(COMP);
    localparam logic        WRAP     = (TOD_FMT == 1);

    logic        rdy_s;
    logic        rdy_d;
    tod_t        base;
    tod_t        cur_q;
    logic [95:0] cur_flat;

    tod_sync_bitsync #(.STAGES(STAGES)) u_rdy_sync (
        .clk (slv_clk),
        .rst (rst),
        .d   (rdy_tgl),
        .q   (rdy_s)
    );

    assign base = tod_t'(96'(word));

    always_ff @(posedge slv_clk) begin
        if (rst) begin
            rdy_d <= 1'b0;
            cur_q <= '0;
            load  <= 1'b0;
            valid <= 1'b0;
        end else begin
            rdy_d <= rdy_s;
            load  <= 1'b0;
            if (rdy_s != rdy_d) begin
                cur_q <= tod_adv(base, COMP_FNS, WRAP);
                load  <= 1'b1;
                valid <= 1'b1;
            end else if (valid) begin
                cur_q <= tod_adv(cur_q, INC, WRAP);
            end
        end
    end

    assign cur_flat = cur_q;
    assign tod      = cur_flat[W-1:0];
endmodule

// File: rtl/tod_sync.sv
`timescale 1ns/1ps
module tod_sync
    import tod_sync_pkg::*;
#(
    parameter int  TOD_FMT     = 1,
    parameter int  SYNC_MODE   = 1,
    parameter int  PERIOD_NS   = 8,
    parameter int  PERIOD_FNS  = 0,
    parameter int  COMP_CYCLES = 3,
    parameter int  RELOAD_GAP  = 16,
    parameter int  SYNC_STAGES = 2,
    localparam int TOD_W       = (TOD_FMT == 1) ? 96 : 64
) (
    input  logic             mst_clk,
    input  logic [TOD_W-1:0] mst_tod,
    input  logic             smp_clk,
    input  logic             slv_clk,
    input  logic             rst,
    output logic [TOD_W-1:0] slv_tod,
    output logic             slv_load,
    output logic             slv_valid
);
    localparam logic [63:0] INC_FNS = mode_inc(SYNC_MODE, PERIOD_NS, PERIOD_FNS);

    logic             req_tgl;
    logic             ack_tgl;
    logic             rdy_tgl;
    logic [TOD_W-1:0] hold;
    logic [TOD_W-1:0] word;

    tod_sync_capture #(.W(TOD_W), .STAGES(SYNC_STAGES)) u_cap (
        .mst_clk (mst_clk),
        .rst     (rst),
        .mst_tod (mst_tod),
        .req_tgl (req_tgl),
        .hold    (hold),
        .ack_tgl (ack_tgl)
    );

    tod_sync_sampler #(.W(TOD_W), .STAGES(SYNC_STAGES), .GAP(RELOAD_GAP)) u_smp (
        .smp_clk (smp_clk),
        .rst     (rst),
        .hold    (hold),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl),
        .word    (word),
        .rdy_tgl (rdy_tgl)
    );

    tod_sync_slave #(
        .W       (TOD_W),
        .STAGES  (SYNC_STAGES),
        .TOD_FMT (TOD_FMT),
        .INC     (INC_FNS),
        .COMP    (COMP_CYCLES)
    ) u_slv (
        .slv_clk (slv_clk),
        .rst     (rst),
        .word    (word),
        .rdy_tgl (rdy_tgl),
        .tod     (slv_tod),
        .load    (slv_load),
        .valid   (slv_valid)
    );
endmodule

// File: rtl/tod_sync_chk.sv
`timescale 1ns/1ps
module tod_sync_chk
    import tod_sync_pkg::*;
#(
    parameter int  TOD_FMT    = 1,
    parameter int  SYNC_MODE  = 1,
    parameter int  PERIOD_NS  = 8,
    parameter int  PERIOD_FNS = 0,
    localparam int W          = (TOD_FMT == 1) ? 96 : 64
) (
    input logic         slv_clk,
    input logic         rst,
    input logic [W-1:0] slv_tod,
    input logic         slv_load,
    input logic         slv_valid
);
    localparam logic [63:0] INC  = mode_inc(SYNC_MODE, PERIOD_NS, PERIOD_FNS);
    localparam logic        WRAP = (TOD_FMT == 1);

    function automatic logic [W-1:0] step(logic [W-1:0] x);
        tod_t        r;
        logic [95:0] f;
        r = tod_adv(tod_t'(96'(x)), INC, WRAP);
        f = r;
        return f[W-1:0];
    endfunction

    assert_free_run_R3: assert property (@(posedge slv_clk) disable iff (rst)
        slv_valid |=> (slv_load || slv_tod == step($past(slv_tod))));

    assert_single_pulse_R8: assert property (@(posedge slv_clk) disable iff (rst)
        slv_load |=> !slv_load);

    assert_valid_sticky_R7: assert property (@(posedge slv_clk) disable iff (rst)
        slv_valid |=> slv_valid);

    assert_invalid_zero_R7: assert property (@(posedge slv_clk) disable iff (rst)
        !slv_valid |-> (slv_tod == '0 && !slv_load));

    assert_load_marks_valid_R7: assert property (@(posedge slv_clk) disable iff (rst)
        slv_load |-> slv_valid);
endmodule

bind tod_sync tod_sync_chk #(
    .TOD_FMT    (TOD_FMT),
    .SYNC_MODE  (SYNC_MODE),
    .PERIOD_NS  (PERIOD_NS),
    .PERIOD_FNS (PERIOD_FNS)
) u_chk (
    .slv_clk   (slv_clk),
    .rst       (rst),
    .slv_tod   (slv_tod),
    .slv_load  (slv_load),
    .slv_valid (slv_valid)
);

// File: tb/tb_tod_sync.sv
`timescale 1ns/1ps
module tb_tod_sync;

    localparam logic [63:0] INC_A = 64'h80000;  // R3: mode 1, 8 ns
    localparam logic [63:0] INC_B = 64'h34000;  // R4: 3 ns + 0x4000
    localparam int          COMP  = 3;

    logic        mst_clk = 1'b0;
    logic        smp_clk = 1'b0;
    logic        slv_clk = 1'b0;
    logic        rst     = 1'b1;
    logic [95:0] mtod_a  = '0;
    logic [63:0] mtod_b  = '0;
    logic [95:0] tod_a;
    logic [63:0] tod_b;
    logic        load_a, load_b, valid_a, valid_b;

    always #3.2 mst_clk = ~mst_clk;
    always #4.9 smp_clk = ~smp_clk;
    always #5   slv_clk = ~slv_clk;   // 100 MHz

    tod_sync dut (
        .mst_clk (mst_clk), .mst_tod (mtod_a), .smp_clk (smp_clk),
        .slv_clk (slv_clk), .rst (rst),
        .slv_tod (tod_a), .slv_load (load_a), .slv_valid (valid_a)
    );

    tod_sync #(.TOD_FMT(0), .SYNC_MODE(2), .PERIOD_NS(3), .PERIOD_FNS(16384)) dut_b (
        .mst_clk (mst_clk), .mst_tod (mtod_b), .smp_clk (smp_clk),
        .slv_clk (slv_clk), .rst (rst),
        .slv_tod (tod_b), .slv_load (load_b), .slv_valid (valid_b)
    );

    int nvec  = 0;
    int nfail = 0;
    int epoch = 0;
    bit done  = 0;

    task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Reference adder: fractional-ns add with optional 1e9 ns rollover into seconds.
    function automatic logic [95:0] m_add(logic [95:0] t, logic [63:0] d, bit wrap);
        logic [31:0] s;
        logic [63:0] v;
        s = t[95:64];
        v = t[63:0] + d;
        if (wrap && v[63:16] >= 48'd1_000_000_000) begin
            v = v - (64'd1_000_000_000 << 16);
            s = s + 32'd1;
        end
        return {s, v};
    endfunction

    // Checker for the 96-bit, mode 1 instance
    int          ep_a = 0, nl_a = 0, good_a = 0;
    bit          seen_a = 0, pv_a = 0, pl_a = 0;
    logic [95:0] pt_a = '0;
    always @(negedge slv_clk) begin
        if (rst) begin
            seen_a = 0; pv_a = 0; pl_a = 0;
        end else begin
            if (ep_a != epoch) begin ep_a = epoch; nl_a = 0; good_a = 0; end
            if (!seen_a && !load_a)
                chk(!valid_a && tod_a == '0, "R7", {95'd0, valid_a} | tod_a, '0);
            if (load_a) begin
                chk(valid_a, "R7", {95'd0, valid_a}, 96'd1);
                chk(!pl_a, "R8", {95'd0, pl_a}, 96'd0);
                seen_a = 1;
                nl_a++;
                if (nl_a >= 2) begin
                    chk(tod_a == m_add(mtod_a, INC_A * COMP, 1'b1), "R5/R6/R1",
                        tod_a, m_add(mtod_a, INC_A * COMP, 1'b1));
                    good_a++;
                end
            end else if (pv_a) begin
                chk(tod_a == m_add(pt_a, INC_A, 1'b1), "R3/R6", tod_a, m_add(pt_a, INC_A, 1'b1));
            end
            pt_a = tod_a; pv_a = valid_a; pl_a = load_a;
        end
    end

    // Checker for the 64-bit, mode 2 instance
    int          ep_b = 0, nl_b = 0, good_b = 0;
    bit          seen_b = 0, pv_b = 0, pl_b = 0;
    logic [63:0] pt_b = '0;
    always @(negedge slv_clk) begin
        if (rst) begin
            seen_b = 0; pv_b = 0; pl_b = 0;
        end else begin
            if (ep_b != epoch) begin ep_b = epoch; nl_b = 0; good_b = 0; end
            if (!seen_b && !load_b)
                chk(!valid_b && tod_b == '0, "R7", 96'(tod_b) | {95'd0, valid_b}, '0);
            if (load_b) begin
                chk(!pl_b, "R8", {95'd0, pl_b}, 96'd0);
                seen_b = 1;
                nl_b++;
                if (nl_b >= 2) begin
                    chk(96'(tod_b) == m_add(96'(mtod_b), INC_B * COMP, 1'b0), "R5/R2",
                        96'(tod_b), m_add(96'(mtod_b), INC_B * COMP, 1'b0));
                    good_b++;
                end
            end else if (pv_b) begin
                chk(96'(tod_b) == m_add(96'(pt_b), INC_B, 1'b0), "R4/R2",
                    96'(tod_b), m_add(96'(pt_b), INC_B, 1'b0));
            end
            pt_b = tod_b; pv_b = valid_b; pl_b = load_b;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (10) @(negedge slv_clk);
        #1 rst = 1'b0;
        for (int e = 0; e < 34; e++) begin
            @(negedge slv_clk);
            #1;
            if (e == 0) begin
                mtod_a = {32'h0000_1234, 48'd999_999_990, 16'hFFFF};   // R6 via compensation
                mtod_b = {48'd999_999_999, 16'h0000};                  // R2: no 1e9 rollover
            end else if (e == 1) begin
                mtod_a = {32'hFFFF_FFFF, 48'd999_999_999, 16'h0000};   // R6 seconds wrap
                mtod_b = 64'hFFFF_FFFF_FFFF_FFF0;                      // R2 modulo 2^64
            end else begin
                mtod_a[95:64] = $urandom;
                mtod_a[63:16] = 48'($urandom % 32'd1_000_000_000);
                mtod_a[15:0]  = 16'($urandom);
                mtod_b        = {$urandom, $urandom};
            end
            epoch++;
            begin
                int t = 0;
                while (!(ep_a == epoch && ep_b == epoch && good_a > 0 && good_b > 0)
                       && t < 2000) begin
                    @(negedge slv_clk);
                    t++;
                end
                chk(t < 2000, "R8", 96'(t), 96'd2000);
            end
        end
        // Reset during operation returns to the invalid state (R7)
        #1 rst = 1'b1;
        repeat (4) @(negedge slv_clk);
        chk(!valid_a && !load_a && tod_a == '0, "R7", tod_a, '0);
        chk(!valid_b && !load_b && tod_b == '0, "R7", 96'(tod_b), '0);
        #1 rst = 1'b0;
        repeat (120) @(negedge slv_clk);
        chk(valid_a && valid_b, "R7", {94'd0, valid_a, valid_b}, 96'd3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule